// File: doc/BRIEF.md
# Bridge PWM Delayed-Trip Gate

This block sits between a PWM generator and the gate drivers of a four-switch bridge. It receives four PWM waveforms that are already fully formed, together with an active-high fault input, a half-cycle polarity select, a 16-bit delay value and a period-start strobe. It returns four registered and gated PWM outputs. When a fault arrives, two legs are blanked at once. They stay blanked until a PWM period boundary that comes after the fault has cleared. A third leg keeps running for a programmed number of clocks and is then forced low. That leg returns to its raw waveform on the first cycle in which the fault is gone. The fourth leg is not affected by the fault.

The polarity input selects which legs take which role. On the positive half-cycle, legs 1A and 1B are blanked at once and leg 2B is the delayed leg. On the negative half-cycle, legs 2A and 2B are blanked at once and leg 1B is the delayed leg. Each delayed leg is the AND of its raw input and an internal enable. The enable drops when a counter reaches the programmed delay. The counter runs only while the synchronized fault is active and returns to zero as soon as the fault clears.

Top module: `bridge_trip_gate`

## Requirements
- R1: While rst_ni is low, all four bits of pwm_o are 0.
- R2: With no fault, pwm_o equals pwm_raw_i one clock later. The bit mapping is bit 0 = leg 1A (S1), bit 1 = leg 2B (S2), bit 2 = leg 1B (S3), bit 3 = leg 2A (S4).
- R3: trip_i goes through a two-stage synchronizer. A change of trip_i therefore first affects pwm_o on the third rising edge after the change.
- R4: With polarity_i = 0 (positive), bits 0 and 2 go low on the first output update after the synchronized fault is seen.
- R5: With polarity_i = 0, bit 1 keeps following its raw input for delay_i clocks after bits 0 and 2 are blanked. It is low from then on while the fault lasts.
- R6: A delay_i of 0 blanks the delayed leg on the same edge as the immediately blanked legs.
- R7: The delayed leg follows its raw input again on the first output update after the synchronized fault clears. No period strobe is needed for this.
- R8: The immediately blanked legs stay low after the fault clears. They are released only on the edge where period_start_i = 1 is sampled while the synchronized fault is inactive. A strobe that arrives during the fault does not release them.
- R9: With polarity_i = 1 (negative), bits 3 and 1 are blanked at once, and bit 2 is the delayed leg with the same timing as in R5.
- R10: The leg that has no role in the selected mode (bit 3 for positive, bit 0 for negative) keeps following its raw input during a fault.
- R11: The delay count restarts from zero for every new fault. A fault shorter than delay_i does not shorten the delay of a later fault.
- R12: An output bit is never 1 unless its raw input was 1 on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_raw_i | input | 4 | Raw PWM legs {2A, 1B, 2B, 1A} |
| trip_i | input | 1 | Fault input, active high, asynchronous |
| polarity_i | input | 1 | 0 = positive half-cycle, 1 = negative half-cycle |
| delay_i | input | 16 | Delay of the delayed leg, in clocks |
| period_start_i | input | 1 | One-clock strobe at each PWM period start |
| pwm_o | output | 4 | Gated PWM legs, registered |

## Verification
The bench first drives a table of raw patterns in both polarities with no fault. This shows that the leg mapping and the one-clock pass-through hold before any gating is involved. Faults are then applied with a nonzero delay, with a zero delay and in the negative mode. Each run separates the immediately blanked legs, the delayed leg and the idle leg by the edge on which each changes. Faults that end inside a period and faults that span period strobes separate the immediate recovery of the delayed leg from the strobe-gated release of the other legs. A fault shorter than the delay, followed by a second fault, shows that the count restarts.

// File: rtl/bridge_trip_pkg.sv
package bridge_trip_pkg;
  localparam int NUM_LEGS = 4;
  localparam int LEG_1A = 0;
  localparam int LEG_2B = 1;
  localparam int LEG_1B = 2;
  localparam int LEG_2A = 3;

  typedef struct packed {
    logic [NUM_LEGS-1:0] cbc;  // blanked at once, released on period strobe
    logic [NUM_LEGS-1:0] dly;  // blanked after the delay, released at once
  } leg_role_t;

  function automatic leg_role_t role_of(input logic neg);
    leg_role_t r;
    r.cbc = '0;
    r.dly = '0;
    if (!neg) begin
      r.cbc[LEG_1A] = 1'b1;
      r.cbc[LEG_1B] = 1'b1;
      r.dly[LEG_2B] = 1'b1;
    end else begin
      r.cbc[LEG_2A] = 1'b1;
      r.cbc[LEG_2B] = 1'b1;
      r.dly[LEG_1B] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], async_i};
  end

  assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/cbc_latch.sv
module cbc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_s_i,
  input  logic period_start_i,
  output logic block_o,
  output logic held_o
);
  logic held_q;

  // release only on a strobe seen with the fault gone
  assign block_o = trip_s_i | (held_q & ~period_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= block_o;
  end

  assign held_o = held_q;
endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trip_s_i,
  input  logic [W-1:0] delay_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!trip_s_i)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX)    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = trip_s_i & (cnt_q >= delay_i);
  assign count_o  = cnt_q;
endmodule

// File: rtl/bridge_trip_gate.sv
module bridge_trip_gate
  import bridge_trip_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_LEGS-1:0] pwm_raw_i,
  input  logic                trip_i,
  input  logic                polarity_i,
  input  logic [DLY_W-1:0]    delay_i,
  input  logic                period_start_i,
  output logic [NUM_LEGS-1:0] pwm_o
);
  logic             trip_s;
  logic             cbc_block;
  logic             cbc_held;
  logic             dly_expire;
  logic [DLY_W-1:0] dly_cnt;
  leg_role_t        role;
  logic [NUM_LEGS-1:0] gate_en;
  logic [NUM_LEGS-1:0] pwm_q;

  trip_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .async_i(trip_i), .sync_o(trip_s)
  );

  cbc_latch u_cbc (
    .clk_i, .rst_ni, .trip_s_i(trip_s), .period_start_i,
    .block_o(cbc_block), .held_o(cbc_held)
  );

  delay_timer #(.W(DLY_W)) u_dly (
    .clk_i, .rst_ni, .trip_s_i(trip_s), .delay_i,
    .count_o(dly_cnt), .expire_o(dly_expire)
  );

  assign role = role_of(polarity_i);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign gate_en[g] = ~(role.cbc[g] & cbc_block) & ~(role.dly[g] & dly_expire);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= '0;
    else         pwm_q <= pwm_raw_i & gate_en;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/bridge_trip_gate_chk.sv
module bridge_trip_gate_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       pwm_raw_i,
  input logic             polarity_i,
  input logic             period_start_i,
  input logic [DLY_W-1:0] delay_i,
  input logic [3:0]       pwm_o,
  input logic             trip_s,
  input logic             cbc_held,
  input logic [DLY_W-1:0] dly_cnt
);
  AST_RESET_LOW: assert property (@(posedge clk_i) !rst_ni |-> pwm_o == 4'b0000); // R1

  AST_POS_CBC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_s && !polarity_i |=> pwm_o[0] == 1'b0 && pwm_o[2] == 1'b0); // R4

  AST_POS_DLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_s && !polarity_i && dly_cnt < delay_i |=> pwm_o[1] == $past(pwm_raw_i[1])); // R5

  AST_POS_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_s && !polarity_i |=> pwm_o[1] == $past(pwm_raw_i[1])); // R7

  AST_CBC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbc_held && !period_start_i && !polarity_i |=> pwm_o[0] == 1'b0); // R8

  AST_NEG_CBC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_s && polarity_i |=> pwm_o[3] == 1'b0 && pwm_o[1] == 1'b0); // R9

  AST_IDLE_LEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !polarity_i |=> pwm_o[3] == $past(pwm_raw_i[3])); // R10

  AST_AND_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pwm_o & ~$past(pwm_raw_i)) == 4'b0000); // R12
endmodule

bind bridge_trip_gate bridge_trip_gate_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i, .rst_ni, .pwm_raw_i, .polarity_i, .period_start_i, .delay_i,
  .pwm_o, .trip_s, .cbc_held, .dly_cnt
);

// File: tb/bridge_trip_gate_test.sv
`timescale 1ns/1ps
module bridge_trip_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  raw = 4'b0000;
  logic        trip = 1'b0;
  logic        pol = 1'b0;
  logic [15:0] dly = 16'd0;
  logic        pstart = 1'b0;
  logic [3:0]  pwm;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_trip_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_raw_i(raw), .trip_i(trip),
    .polarity_i(pol), .delay_i(dly), .period_start_i(pstart), .pwm_o(pwm)
  );

  // {raw, pol, expected}
  localparam logic [8:0] VEC [8] = '{
    {4'b0000, 1'b0, 4'b0000}, {4'b1111, 1'b0, 4'b1111},
    {4'b0101, 1'b0, 4'b0101}, {4'b1010, 1'b0, 4'b1010},
    {4'b0001, 1'b1, 4'b0001}, {4'b1000, 1'b1, 4'b1000},
    {4'b0110, 1'b1, 4'b0110}, {4'b1111, 1'b1, 4'b1111}
  };

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (pwm !== exp) begin
      errors++;
      $display("FAIL %s: pwm_o=%b expected %b", req, pwm, exp);
    end
  endtask

  task automatic chk_bit(input string req, input int b, input logic exp);
    checks++;
    if (pwm[b] !== exp) begin
      errors++;
      $display("FAIL %s: pwm_o[%0d]=%b expected %b", req, b, pwm[b], exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe();
    pstart = 1'b1;
    edges(1);
    pstart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    raw = 4'b1111;
    edges(3);
    chk("R1 reset", 4'b0000);
    rst_n = 1'b1;
    edges(1);

    for (int i = 0; i < 8; i++) begin
      raw = VEC[i][8:5];
      pol = VEC[i][4];
      edges(1);
      chk("R2 passthrough", VEC[i][3:0]);
    end

    // positive, delay 5, strobe during fault
    pol = 1'b0; dly = 16'd5; raw = 4'b1111;
    edges(1);
    trip = 1'b1;
    edges(2);
    chk("R3 sync latency", 4'b1111);
    edges(1);
    chk("R4 pos cbc", 4'b1010);
    edges(4);
    chk_bit("R5 delayed hold", 1, 1'b1);
    strobe();
    chk("R5 delayed off", 4'b1000);
    raw = 4'b0111;
    edges(1);
    chk("R10 idle leg pos", 4'b0000);
    raw = 4'b1111;
    trip = 1'b0;
    edges(3);
    chk("R7 delayed recover", 4'b1010);
    edges(4);
    chk("R8 held without strobe", 4'b1010);
    strobe();
    chk("R8 strobe release", 4'b1111);

    // zero delay
    dly = 16'd0;
    trip = 1'b1;
    edges(3);
    chk("R6 zero delay", 4'b1000);
    trip = 1'b0;
    edges(3);
    strobe();
    chk("R6 release", 4'b1111);

    // negative, delay 3
    pol = 1'b1; dly = 16'd3;
    edges(1);
    trip = 1'b1;
    edges(3);
    chk("R9 neg cbc", 4'b0101);
    raw = 4'b1110;
    edges(1);
    chk("R10 idle leg neg", 4'b0100);
    raw = 4'b1111;
    edges(2);
    chk("R9 neg delayed off", 4'b0001);
    trip = 1'b0;
    edges(3);
    chk("R9 neg recover", 4'b0101);
    strobe();
    chk("R9 neg release", 4'b1111);

    // count restart: short fault then full fault
    pol = 1'b0; dly = 16'd6;
    edges(1);
    trip = 1'b1;
    edges(4);
    trip = 1'b0;
    edges(3);
    strobe();
    chk("R11 short fault clear", 4'b1111);
    trip = 1'b1;
    edges(8);
    chk_bit("R11 restart hold", 1, 1'b1);
    edges(1);
    chk_bit("R11 restart off", 1, 1'b0);
    trip = 1'b0;
    edges(3);
    strobe();

    // AND gating during a running delay
    dly = 16'd40;
    trip = 1'b1;
    edges(3);
    raw = 4'b1101;
    edges(1);
    chk_bit("R12 raw low", 1, 1'b0);
    raw = 4'b1111;
    edges(1);
    chk_bit("R12 raw high", 1, 1'b1);
    trip = 1'b0;
    edges(3);
    strobe();
    chk("R8 final release", 4'b1111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule